// File: doc/BRIEF.md
# Tagged Register Stack Controller

This block keeps a small bank of wide registers that software-visible instructions treat as a last-in, first-out stack. Operands are not named by fixed register numbers. They are named by their distance from a moving top pointer: relative index 0 is the top entry, and relative index i is the entry i places below it. The physical slot is (top + i) mod DEPTH. Every slot carries a valid tag, so the controller knows which entries hold live values.

Each cycle the block accepts one command. It can clear the stack, push a loaded value, push zero, read the top entry with or without a pop, or write back an arithmetic result. The result can go to the top entry or to a relative entry, and the write-back can be followed by a pop. The arithmetic unit sits outside the block. The controller supplies the two operands combinationally on `opa_data` and `opb_data` and accepts the finished value on `result_data`. A push into a live slot is refused and flags overflow. A command that reads an empty slot is refused and flags underflow. A refused command leaves all state unchanged.

Top module: `fpstack_mgr`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `top_ptr` is 0, `tag_valid` is all zeros, and `overflow`, `underflow` and `store_valid` are 0.
- R2: Command 2 (push load) and command 3 (push zero) have the same effect when the slot at (top−1) mod DEPTH is empty. At the next edge `top_ptr` becomes that slot, its tag becomes valid, and its data becomes `load_data` for command 2 or all zeros for command 3.
- R3: A push (command 2 or 3) whose target slot is already valid raises `overflow` for exactly one cycle after the edge. It leaves `top_ptr`, the tags and all slot data unchanged.
- R4: `opa_data` always shows the data of physical slot `top_ptr`. `opb_data` always shows the data of slot (`top_ptr` + `idx`) mod DEPTH.
- R5: Command 4 (store) with a valid top raises `store_valid` for one cycle after the edge, with `store_data` equal to the top entry's data from before the edge. The pointer and the tags do not change.
- R6: Command 5 (store and pop) with a valid top outputs the data as in R5. It also clears the tag of the old top and increments `top_ptr` mod DEPTH.
- R7: Several commands raise `underflow` for one cycle after the edge and change nothing:
  - a store (command 4 or 5) whose top slot is empty;
  - an update (command 6, 7 or 8) whose top slot or relative slot is empty.
  `store_valid` stays 0 in that cycle, and at most one of `overflow`, `underflow` and `store_valid` is high at any time.
- R8: Command 6 writes `result_data` into the top slot. Command 7 writes it into slot (top + `idx`) mod DEPTH. Both require the two operand slots to be valid, and the pointer and the tags are unchanged.
- R9: Command 8 writes `result_data` into slot (top + `idx`) mod DEPTH, then clears the old top's tag and increments `top_ptr`.
- R10: Command 1 (initialise) sets `top_ptr` to 0 and clears every tag, whatever the previous state.
- R11: Command 0 (idle), and any code above 8, changes no pointer, tag or data and raises no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 4 | Command code (0 idle … 8 update-and-pop) |
| idx | input | 3 | Relative index i, log2(DEPTH) bits |
| load_data | input | 64 | Value for a push-load, WIDTH bits |
| result_data | input | 64 | Arithmetic result to write back, WIDTH bits |
| opa_data | output | 64 | Data of the top entry |
| opb_data | output | 64 | Data of the entry idx places below the top |
| store_valid | output | 1 | Store output valid, one cycle |
| store_data | output | 64 | Value read by a store |
| top_ptr | output | 3 | Physical slot of the current top |
| tag_valid | output | 8 | Per-slot valid tags, bit n for slot n |
| overflow | output | 1 | Push refused, one-cycle pulse |
| underflow | output | 1 | Read of an empty entry refused, one-cycle pulse |

## Verification
The bench builds the block with its default eight slots of 64 bits. With eight slots, filling the stack walks the three-bit pointer through every value and wraps it from 0 to 7. It also puts every relative index 0 to 7 in reach. A ninth push then hits a live slot and exposes the overflow path. Because the model treats slots as a plain modulo-eight array, mistakes in the wrap of the pointer, in pop after a write-back at index 0, and in operand readout after a wrap all show up as data mismatches.

// File: rtl/fpstk_pkg.sv
`timescale 1ns/1ps
package fpstk_pkg;

    parameter int unsigned FPS_DEPTH = 8;
    parameter int unsigned FPS_WIDTH = 64;

    typedef enum logic [3:0] {
        OP_IDLE   = 4'd0,
        OP_INIT   = 4'd1,
        OP_PUSH   = 4'd2,
        OP_PUSHZ  = 4'd3,
        OP_STORE  = 4'd4,
        OP_STOREP = 4'd5,
        OP_UPD0   = 4'd6,
        OP_UPDI   = 4'd7,
        OP_UPDIP  = 4'd8
    } fps_op_e;

    typedef enum logic [1:0] {
        SRC_LOAD   = 2'd0,
        SRC_ZERO   = 2'd1,
        SRC_RESULT = 2'd2
    } fps_src_e;

    typedef struct packed {
        logic     en;
        fps_src_e src;
    } fps_wr_t;

    function automatic logic is_push(input fps_op_e o);
        return (o == OP_PUSH) || (o == OP_PUSHZ);
    endfunction

    function automatic logic is_update(input fps_op_e o);
        return (o == OP_UPD0) || (o == OP_UPDI) || (o == OP_UPDIP);
    endfunction

endpackage

// File: rtl/fpstk_regfile.sv
`timescale 1ns/1ps
module fpstk_regfile
    import fpstk_pkg::*;
#(
    parameter int unsigned DEPTH = FPS_DEPTH,
    parameter int unsigned WIDTH = FPS_WIDTH,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [PTR_W-1:0] ra,
    input  logic [PTR_W-1:0] rb,
    output logic [WIDTH-1:0] rda,
    output logic [WIDTH-1:0] rdb
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [DEPTH-1:0] slot_hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_dec
        assign slot_hit[g] = we && (waddr == PTR_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < DEPTH; n++) mem[n] <= '0;
        end else begin
            for (int n = 0; n < DEPTH; n++)
                if (slot_hit[n]) mem[n] <= wdata;
        end
    end

    assign rda = mem[ra];
    assign rdb = mem[rb];

endmodule

// File: rtl/fpstk_ctrl.sv
`timescale 1ns/1ps
module fpstk_ctrl
    import fpstk_pkg::*;
#(
    parameter int unsigned DEPTH = FPS_DEPTH,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       op,
    input  logic [PTR_W-1:0] idx,
    output logic [PTR_W-1:0] top_q,
    output logic [DEPTH-1:0] tags_q,
    output logic             ovf_q,
    output logic             unf_q,
    output fps_wr_t          wr,
    output logic [PTR_W-1:0] wr_slot,
    output logic [PTR_W-1:0] rel_slot,
    output logic             rd_fire
);

    fps_op_e          op_e;
    logic [PTR_W-1:0] push_slot, pop_next;
    logic [PTR_W-1:0] nxt_top;
    logic [DEPTH-1:0] nxt_tags;
    logic             ovf_d, unf_d;

    assign op_e      = fps_op_e'(op);
    assign rel_slot  = top_q + idx;
    assign push_slot = top_q - PTR_W'(1);
    assign pop_next  = top_q + PTR_W'(1);

    always_comb begin
        nxt_top  = top_q;
        nxt_tags = tags_q;
        wr       = '{en: 1'b0, src: SRC_RESULT};
        wr_slot  = top_q;
        ovf_d    = 1'b0;
        unf_d    = 1'b0;
        rd_fire  = 1'b0;
        if (op_e == OP_INIT) begin
            nxt_top  = '0;
            nxt_tags = '0;
        end else if (is_push(op_e)) begin
            if (tags_q[push_slot]) begin
                ovf_d = 1'b1;
            end else begin
                wr                  = '{en: 1'b1, src: (op_e == OP_PUSHZ) ? SRC_ZERO : SRC_LOAD};
                wr_slot             = push_slot;
                nxt_tags[push_slot] = 1'b1;
                nxt_top             = push_slot;
            end
        end else if (op_e == OP_STORE || op_e == OP_STOREP) begin
            if (!tags_q[top_q]) begin
                unf_d = 1'b1;
            end else begin
                rd_fire = 1'b1;
                if (op_e == OP_STOREP) begin
                    nxt_tags[top_q] = 1'b0;
                    nxt_top         = pop_next;
                end
            end
        end else if (is_update(op_e)) begin
            if (!(tags_q[top_q] && tags_q[rel_slot])) begin
                unf_d = 1'b1;
            end else begin
                wr      = '{en: 1'b1, src: SRC_RESULT};
                wr_slot = (op_e == OP_UPD0) ? top_q : rel_slot;
                if (op_e == OP_UPDIP) begin
                    nxt_tags[top_q] = 1'b0;
                    nxt_top         = pop_next;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q  <= '0;
            tags_q <= '0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            top_q  <= nxt_top;
            tags_q <= nxt_tags;
            ovf_q  <= ovf_d;
            unf_q  <= unf_d;
        end
    end

endmodule

// File: rtl/fpstack_mgr.sv
`timescale 1ns/1ps
module fpstack_mgr
    import fpstk_pkg::*;
#(
    parameter int unsigned DEPTH = FPS_DEPTH,
    parameter int unsigned WIDTH = FPS_WIDTH,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       op,
    input  logic [PTR_W-1:0] idx,
    input  logic [WIDTH-1:0] load_data,
    input  logic [WIDTH-1:0] result_data,
    output logic [WIDTH-1:0] opa_data,
    output logic [WIDTH-1:0] opb_data,
    output logic             store_valid,
    output logic [WIDTH-1:0] store_data,
    output logic [PTR_W-1:0] top_ptr,
    output logic [DEPTH-1:0] tag_valid,
    output logic             overflow,
    output logic             underflow
);

    fps_wr_t          wr;
    logic [PTR_W-1:0] wr_slot, rel_slot;
    logic             rd_fire;
    logic [WIDTH-1:0] wdata;

    fpstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .idx     (idx),
        .top_q   (top_ptr),
        .tags_q  (tag_valid),
        .ovf_q   (overflow),
        .unf_q   (underflow),
        .wr      (wr),
        .wr_slot (wr_slot),
        .rel_slot(rel_slot),
        .rd_fire (rd_fire)
    );

    always_comb begin
        unique case (wr.src)
            SRC_LOAD: wdata = load_data;
            SRC_ZERO: wdata = '0;
            default:  wdata = result_data;
        endcase
    end

    fpstk_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .we   (wr.en),
        .waddr(wr_slot),
        .wdata(wdata),
        .ra   (top_ptr),
        .rb   (rel_slot),
        .rda  (opa_data),
        .rdb  (opb_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            store_valid <= 1'b0;
            store_data  <= '0;
        end else begin
            store_valid <= rd_fire;
            if (rd_fire) store_data <= opa_data;
        end
    end

endmodule

// File: rtl/fpstack_mgr_chk.sv
`timescale 1ns/1ps
module fpstack_mgr_chk
    import fpstk_pkg::*;
#(
    parameter int unsigned DEPTH = FPS_DEPTH,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       op,
    input logic             store_valid,
    input logic [PTR_W-1:0] top_ptr,
    input logic [DEPTH-1:0] tag_valid,
    input logic             overflow,
    input logic             underflow
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (top_ptr == '0 && tag_valid == '0 && !overflow && !underflow && !store_valid));

    p_push_moves_top_r2: assert property (@(posedge clk) disable iff (rst)
        ((op == OP_PUSH || op == OP_PUSHZ) && !tag_valid[PTR_W'(top_ptr - PTR_W'(1))])
        |=> (top_ptr == PTR_W'($past(top_ptr) - PTR_W'(1)) && tag_valid[top_ptr]));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        overflow |-> (top_ptr == $past(top_ptr) && tag_valid == $past(tag_valid)));

    p_store_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        (store_valid && $past(op) == OP_STORE) |-> ($stable(top_ptr) && $stable(tag_valid)));

    p_store_pop_r6: assert property (@(posedge clk) disable iff (rst)
        (store_valid && $past(op) == OP_STOREP)
        |-> (top_ptr == PTR_W'($past(top_ptr) + PTR_W'(1)) && !tag_valid[$past(top_ptr)]));

    p_underflow_hold_r7: assert property (@(posedge clk) disable iff (rst)
        underflow |-> (top_ptr == $past(top_ptr) && tag_valid == $past(tag_valid)));

    p_outcome_excl_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({overflow, underflow, store_valid}));

    p_init_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (op == OP_INIT) |=> (top_ptr == '0 && tag_valid == '0));

endmodule

bind fpstack_mgr fpstack_mgr_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op         (op),
    .store_valid(store_valid),
    .top_ptr    (top_ptr),
    .tag_valid  (tag_valid),
    .overflow   (overflow),
    .underflow  (underflow)
);

// File: tb/fpstack_mgr_tb.sv
`timescale 1ns/1ps
module fpstack_mgr_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op = 4'd0;
    logic [2:0]  idx = 3'd0;
    logic [63:0] load_data = '0, result_data = '0;
    logic [63:0] opa_data, opb_data, store_data;
    logic        store_valid, overflow, underflow;
    logic [2:0]  top_ptr;
    logic [7:0]  tag_valid;

    int tests = 0, fails = 0;
    bit done = 0;

    int          mtop;
    logic [63:0] mreg [8];
    logic [7:0]  mtag;

    always #5 clk = ~clk;

    fpstack_mgr u_dut (.*);

    task automatic chk(input string r, input string what, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", r, what, got, exp);
        end
    endtask

    function automatic string req_of(input int o);
        case (o)
            1: return "R10";
            2, 3: return "R2";
            4: return "R5";
            5: return "R6";
            6, 7: return "R8";
            8: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic do_op(input int o, input int i, input logic [63:0] ld, input logic [63:0] res);
        int rs, ps;
        bit e_ovf, e_unf, e_sv;
        logic [63:0] e_sd;
        string r;
        @(negedge clk);
        op = 4'(o); idx = 3'(i); load_data = ld; result_data = res;
        #1;
        rs = (mtop + i) % 8;
        if (mtag[mtop]) chk("R4", "opa_data", opa_data, mreg[mtop]);
        if (mtag[rs])   chk("R4", "opb_data", opb_data, mreg[rs]);
        e_ovf = 0; e_unf = 0; e_sv = 0; e_sd = '0;
        r = req_of(o);
        ps = (mtop + 7) % 8;
        case (o)
            1: begin mtop = 0; mtag = '0; end
            2, 3: if (mtag[ps]) begin e_ovf = 1; r = "R3"; end
                  else begin mreg[ps] = (o == 2) ? ld : '0; mtag[ps] = 1; mtop = ps; end
            4, 5: if (!mtag[mtop]) begin e_unf = 1; r = "R7"; end
                  else begin
                      e_sv = 1; e_sd = mreg[mtop];
                      if (o == 5) begin mtag[mtop] = 0; mtop = (mtop + 1) % 8; end
                  end
            6, 7, 8: if (!(mtag[mtop] && mtag[rs])) begin e_unf = 1; r = "R7"; end
                  else begin
                      mreg[(o == 6) ? mtop : rs] = res;
                      if (o == 8) begin mtag[mtop] = 0; mtop = (mtop + 1) % 8; end
                  end
            default: ;
        endcase
        @(posedge clk); #1;
        chk(r, "top_ptr", 64'(top_ptr), 64'(mtop));
        chk(r, "tag_valid", 64'(tag_valid), 64'(mtag));
        chk(e_ovf ? "R3" : r, "overflow", 64'(overflow), 64'(e_ovf));
        chk(e_unf ? "R7" : r, "underflow", 64'(underflow), 64'(e_unf));
        chk(r, "store_valid", 64'(store_valid), 64'(e_sv));
        if (e_sv) chk(r, "store_data", store_data, e_sd);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        mtop = 0; mtag = '0;
        for (int n = 0; n < 8; n++) mreg[n] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: state while in reset
        chk("R1", "top_ptr in reset", 64'(top_ptr), 0);
        chk("R1", "tag_valid in reset", 64'(tag_valid), 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R1", "flags after reset", 64'({overflow, underflow, store_valid}), 0);
        chk("R1", "top after reset", 64'(top_ptr), 0);

        do_op(0, 0, '0, '0);                 // R11 idle
        do_op(4, 0, '0, '0);                 // R7 store on empty
        do_op(6, 0, '0, 64'h1);              // R7 update on empty
        for (int k = 0; k < 8; k++)          // R2 fill, pointer wraps 0 -> 7
            do_op(2, 0, 64'hA000_0000_0000_0000 + 64'(k), '0);
        do_op(2, 0, 64'hDEAD, '0);           // R3 overflow
        do_op(3, 0, '0, '0);                 // R3 overflow on push-zero
        for (int k = 0; k < 8; k++) do_op(0, k, '0, '0);   // R4 sweep
        do_op(4, 0, '0, '0);                 // R5
        do_op(5, 0, '0, '0);                 // R6
        do_op(5, 0, '0, '0);                 // R6
        do_op(3, 0, '0, '0);                 // R2 push zero
        do_op(6, 3, '0, 64'h1111);           // R8 to top
        do_op(7, 3, '0, 64'h2222);           // R8 to ST(i)
        do_op(8, 2, '0, 64'h3333);           // R9
        do_op(8, 0, '0, 64'h4444);           // R9 index zero
        do_op(9, 1, 64'h5, 64'h5);           // R11 unused code
        do_op(1, 0, '0, '0);                 // R10
        do_op(5, 0, '0, '0);                 // R7 after init
        do_op(2, 0, 64'h77, '0);             // R2 after init
        do_op(7, 1, '0, 64'h88);             // R7 relative slot empty
        for (int k = 0; k < 600; k++) begin
            int o;
            o = $urandom_range(0, 9);
            if (o == 1 && $urandom_range(0, 3) != 0) o = 2;
            do_op(o, $urandom_range(0, 7), {$urandom, $urandom}, {$urandom, $urandom});
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule